// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when the contents of a battery-less SRAM are copied into nonvolatile cells (a store) and when they are brought back (a recall). It watches a supply-good flag, software store and recall requests, an open-drain hardware store line and the SRAM write strobes. It issues one-cycle start pulses to the store engine and to the two recall steps, clear followed by transfer. It also drives a memory-access inhibit and pulls the hardware line low while a store is pending or running.

A write-pending flag records whether the SRAM has changed since the last completed store or recall. Every store request, whether it comes from a power failure, the hardware line or software, is dropped while that flag is clear. A hardware request first opens a grace window of `GRACE_CYCLES` cycles. SRAM cycles already under way can finish inside it before the store begins. An engine that does not report done within `TIMEOUT_CYCLES` cycles raises a sticky error flag, and the controller goes back to idle.

Top module: `persist_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_inhibit` is 1. All three start pulses are 0, `line_pull_low` is 0 and `timeout_err` is 0, and the sequencer waits for the supply to come up.
- R2: In the power-up or powered-down state, the first clock edge that samples `supply_ok`=1 makes `clear_start` 1 for exactly the following cycle.
- R3: A recall sequence runs in a fixed order. The edge that samples `clear_done` makes `xfer_start` 1 for the following cycle. The edge that samples `xfer_done` ends the recall, and `mem_inhibit` falls if the supply is good.
- R4: `mem_inhibit` is 1 whenever `supply_ok` is 0 and during any store or recall step. A write strobe that arrives while it is 1 does not mark the SRAM as modified.
- R5: When the edge samples `supply_ok`=0 in idle with the SRAM modified, `store_start` is 1 for the next cycle.
- R6: When the supply fails with the SRAM unmodified, no store starts. The sequencer goes to the powered-down state with `mem_inhibit` held at 1.
- R7: In idle with the SRAM modified, a low level on `hw_line_in` starts the grace window. `line_pull_low` is 1 from the next cycle, and `mem_inhibit` stays 0 for `GRACE_CYCLES` cycles. `store_start` then pulses, and `line_pull_low` stays 1 until the edge that samples `store_done`.
- R8: A software store request starts a store on the next cycle if the SRAM is modified, counting a write accepted in the same cycle. Otherwise the request is dropped. A software recall request starts a recall. When both requests arrive in the same cycle, the store wins whenever it is not dropped.
- R9: A supply failure outranks software requests sampled in the same cycle. The result is a store if the SRAM is modified and the powered-down state otherwise.
- R10: Store or recall requests that arrive while an operation is running are discarded. Nothing starts after the operation ends.
- R11: If an engine step sees no done for `TIMEOUT_CYCLES` cycles, `timeout_err` becomes 1 and stays 1 until reset, and the sequencer returns to idle.
- R12: A completed store or recall clears the modified state. A later store request with no write in between is dropped.
- R13: A supply failure during the grace window starts the store on the next cycle without waiting for the window to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above switch threshold |
| sw_store_req | input | 1 | Software store request |
| sw_recall_req | input | 1 | Software recall request |
| hw_line_in | input | 1 | Sensed level of the open-drain store/busy line (low = request) |
| sram_wr | input | 1 | SRAM write strobe |
| store_done | input | 1 | Store engine finished |
| clear_done | input | 1 | Recall clear step finished |
| xfer_done | input | 1 | Recall transfer step finished |
| mem_inhibit | output | 1 | SRAM reads and writes blocked |
| store_start | output | 1 | One-cycle store engine start |
| clear_start | output | 1 | One-cycle recall clear start |
| xfer_start | output | 1 | One-cycle recall transfer start |
| line_pull_low | output | 1 | Drive the open-drain line low |
| timeout_err | output | 1 | Sticky engine timeout flag |

## Verification
Several events can land in the idle decision cycle together: a supply failure, a software store, a software recall and the presence of earlier writes. The bench sweeps all sixteen combinations from a clean idle state. It compares the resulting start pulse and the inhibit level against a priority formula computed in the bench. Two more collisions are provoked on purpose. One is a write in the same cycle as a software store, which must count as modification. The other is a supply failure inside the hardware grace window, which must start the store at once.

// File: rtl/persist_pkg.sv
package persist_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_GRACE,
        ST_STORE,
        ST_CLEAR,
        ST_XFER,
        ST_DOWN
    } seq_state_t;

    typedef struct packed {
        logic store;
        logic clear;
        logic xfer;
    } eng_start_t;

    // SRAM access is allowed only in idle and during the grace window
    function automatic logic blocks_access(seq_state_t s);
        return (s != ST_IDLE) && (s != ST_GRACE);
    endfunction

    function automatic logic is_engine_step(seq_state_t s);
        return (s == ST_STORE) || (s == ST_CLEAR) || (s == ST_XFER);
    endfunction

    function automatic seq_state_t after_op(logic supply_good);
        return supply_good ? ST_IDLE : ST_DOWN;
    endfunction

endpackage

// File: rtl/persist_count.sv
module persist_count #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run && !hit) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign hit = run && (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/persist_seq.sv
module persist_seq
    import persist_pkg::*;
#(
    parameter int GRACE_CYCLES   = 8,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic hw_line_in,
    input  logic sram_wr,
    input  logic store_done,
    input  logic clear_done,
    input  logic xfer_done,
    output logic mem_inhibit,
    output logic store_start,
    output logic clear_start,
    output logic xfer_start,
    output logic line_pull_low,
    output logic timeout_err
);
    seq_state_t state_q, state_d;
    eng_start_t start_q, start_d;
    logic       dirty_q, dirty_now, wr_taken, op_ok;
    logic       grace_hit, tmo_hit, restart;

    assign mem_inhibit   = blocks_access(state_q) || !supply_ok;
    assign wr_taken      = sram_wr && !mem_inhibit;
    assign dirty_now     = dirty_q || wr_taken;
    assign line_pull_low = (state_q == ST_GRACE) || (state_q == ST_STORE);
    assign restart       = (state_d != state_q);
    assign op_ok         = ((state_q == ST_STORE) && store_done) ||
                           ((state_q == ST_XFER) && xfer_done);

    persist_count #(.LIMIT(GRACE_CYCLES)) u_grace (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .run    (state_q == ST_GRACE),
        .hit    (grace_hit)
    );

    persist_count #(.LIMIT(TIMEOUT_CYCLES)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .run    (is_engine_step(state_q)),
        .hit    (tmo_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP, ST_DOWN: begin
                if (supply_ok) state_d = ST_CLEAR;
            end
            ST_IDLE: begin
                if (!supply_ok)                  state_d = dirty_q ? ST_STORE : ST_DOWN;
                else if (!hw_line_in && dirty_now) state_d = ST_GRACE;
                else if (sw_store_req && dirty_now) state_d = ST_STORE;
                else if (sw_recall_req)          state_d = ST_CLEAR;
            end
            ST_GRACE: begin
                if (!supply_ok || grace_hit) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (store_done || tmo_hit) state_d = after_op(supply_ok);
            end
            ST_CLEAR: begin
                if (clear_done)   state_d = ST_XFER;
                else if (tmo_hit) state_d = after_op(supply_ok);
            end
            ST_XFER: begin
                if (xfer_done || tmo_hit) state_d = after_op(supply_ok);
            end
            default: state_d = ST_PWRUP;
        endcase
    end

    always_comb begin
        start_d.store = (state_d == ST_STORE) && (state_q != ST_STORE);
        start_d.clear = (state_d == ST_CLEAR) && (state_q != ST_CLEAR);
        start_d.xfer  = (state_d == ST_XFER)  && (state_q != ST_XFER);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_PWRUP;
            start_q     <= '0;
            dirty_q     <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
            if (op_ok)         dirty_q <= 1'b0;
            else if (wr_taken) dirty_q <= 1'b1;
            if (tmo_hit && !op_ok && !((state_q == ST_CLEAR) && clear_done))
                timeout_err <= 1'b1;
        end
    end

    assign store_start = start_q.store;
    assign clear_start = start_q.clear;
    assign xfer_start  = start_q.xfer;

endmodule

// File: rtl/persist_seq_chk.sv
module persist_seq_chk (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic clear_done,
    input logic mem_inhibit,
    input logic store_start,
    input logic clear_start,
    input logic xfer_start,
    input logic line_pull_low,
    input logic timeout_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (mem_inhibit && !store_start && !clear_start && !xfer_start && !timeout_err));

    assert_single_start_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_start, clear_start, xfer_start}));

    assert_xfer_follows_clear_R3: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(clear_done));

    assert_low_supply_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> mem_inhibit);

    assert_start_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (store_start || clear_start || xfer_start) |-> mem_inhibit);

    assert_store_pulls_line_R7: assert property (@(posedge clk) disable iff (rst)
        store_start |-> line_pull_low);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err);

endmodule

bind persist_seq persist_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .clear_done   (clear_done),
    .mem_inhibit  (mem_inhibit),
    .store_start  (store_start),
    .clear_start  (clear_start),
    .xfer_start   (xfer_start),
    .line_pull_low(line_pull_low),
    .timeout_err  (timeout_err)
);

// File: tb/persist_seq_bench.sv
module persist_seq_bench;
    localparam int GRACE = 3;
    localparam int TMO   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, sw_store_req = 1'b0, sw_recall_req = 1'b0;
    logic ext_pull = 1'b0, sram_wr = 1'b0;
    logic store_done = 1'b0, clear_done = 1'b0, xfer_done = 1'b0;
    logic mem_inhibit, store_start, clear_start, xfer_start, line_pull_low, timeout_err;
    logic hw_line_in;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign hw_line_in = !(ext_pull || line_pull_low);

    persist_seq #(.GRACE_CYCLES(GRACE), .TIMEOUT_CYCLES(TMO)) u_persist_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
        .hw_line_in(hw_line_in), .sram_wr(sram_wr),
        .store_done(store_done), .clear_done(clear_done), .xfer_done(xfer_done),
        .mem_inhibit(mem_inhibit), .store_start(store_start),
        .clear_start(clear_start), .xfer_start(xfer_start),
        .line_pull_low(line_pull_low), .timeout_err(timeout_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // in the clear step: finish both recall steps
    task automatic finish_recall();
        clear_done = 1'b1; tick(); clear_done = 1'b0;
        chk("R3 xfer_start after clear_done", xfer_start, 1'b1);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R3 inhibit released after transfer", mem_inhibit, !supply_ok);
    endtask

    task automatic write_once();
        sram_wr = 1'b1; tick(); sram_wr = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R1 inhibit in reset", mem_inhibit, 1'b1);
        rst = 1'b0;
        tick();
        chk("R1 inhibit after reset", mem_inhibit, 1'b1);
        chk("R1 no store start", store_start, 1'b0);
        chk("R1 no clear start", clear_start, 1'b0);
        chk("R1 line released", line_pull_low, 1'b0);
        chk("R1 no error", timeout_err, 1'b0);
        tick(); tick();
        chk("R2 waits for supply", clear_start, 1'b0);

        supply_ok = 1'b1; tick();
        chk("R2 power-up recall clear_start", clear_start, 1'b1);
        tick();
        chk("R2 clear_start one cycle", clear_start, 1'b0);
        chk("R3 no transfer before clear_done", xfer_start, 1'b0);
        chk("R4 inhibit during recall", mem_inhibit, 1'b1);
        finish_recall();

        // R5 R6 R8 R9: exhaustive sweep of the idle decision cycle
        for (int c = 0; c < 16; c++) begin
            logic d, f, ss, sr, es, ec;
            d = c[3]; f = c[2]; ss = c[1]; sr = c[0];
            if (d) write_once();
            supply_ok = !f; sw_store_req = ss; sw_recall_req = sr;
            tick();
            sw_store_req = 1'b0; sw_recall_req = 1'b0;
            es = f ? d : (ss && d);
            ec = !f && !(ss && d) && sr;
            chk("R9 sweep store_start", store_start, es);
            chk("R8 sweep clear_start", clear_start, ec);
            chk("R6 sweep inhibit", mem_inhibit, f || es || ec);
            if (es) begin
                store_done = 1'b1; tick(); store_done = 1'b0;
            end
            if (ec) finish_recall();
            if (f) begin
                supply_ok = 1'b1; tick();
                chk("R2 recall on supply return", clear_start, 1'b1);
                finish_recall();
            end
        end

        // R8 write in the same cycle as a software store counts
        sram_wr = 1'b1; sw_store_req = 1'b1; tick();
        sram_wr = 1'b0; sw_store_req = 1'b0;
        chk("R8 same-cycle write then store", store_start, 1'b1);
        store_done = 1'b1; tick(); store_done = 1'b0;
        // R12 clean after store: second store dropped
        sw_store_req = 1'b1; tick(); sw_store_req = 1'b0;
        chk("R12 clean store dropped", store_start, 1'b0);
        chk("R12 still idle", mem_inhibit, 1'b0);

        // R4 writes during a recall are ignored
        sw_recall_req = 1'b1; tick(); sw_recall_req = 1'b0;
        sram_wr = 1'b1; tick(); sram_wr = 1'b0;
        chk("R4 inhibit during clear", mem_inhibit, 1'b1);
        finish_recall();
        supply_ok = 1'b0; tick();
        chk("R4 ignored write left block clean", store_start, 1'b0);
        supply_ok = 1'b1; tick();
        finish_recall();

        // R7 hardware store with grace window
        write_once();
        ext_pull = 1'b1; tick(); ext_pull = 1'b0;
        chk("R7 line held low in grace", line_pull_low, 1'b1);
        chk("R7 access open in grace", mem_inhibit, 1'b0);
        for (int k = 1; k < GRACE; k++) begin
            tick();
            chk("R7 grace continues", store_start, 1'b0);
            chk("R7 grace access open", mem_inhibit, 1'b0);
        end
        tick();
        chk("R7 store after grace", store_start, 1'b1);
        tick(); tick();
        chk("R7 line low during store", line_pull_low, 1'b1);
        store_done = 1'b1; tick(); store_done = 1'b0;
        chk("R7 line released after done", line_pull_low, 1'b0);
        // clean hardware request is dropped
        ext_pull = 1'b1; tick();
        chk("R7 clean request no grace", line_pull_low, 1'b0);
        for (int k = 0; k < GRACE + 1; k++) tick();
        ext_pull = 1'b0;
        chk("R7 clean request no store", store_start, 1'b0);

        // R13 supply failure inside grace
        write_once();
        ext_pull = 1'b1; tick(); ext_pull = 1'b0;
        supply_ok = 1'b0; tick();
        chk("R13 store on failure in grace", store_start, 1'b1);
        store_done = 1'b1; tick(); store_done = 1'b0;
        chk("R6 down after store", mem_inhibit, 1'b1);
        supply_ok = 1'b1; tick();
        finish_recall();

        // R10 requests during a store are discarded
        write_once();
        sw_store_req = 1'b1; tick(); sw_store_req = 1'b0;
        sw_recall_req = 1'b1; sram_wr = 1'b1; tick();
        sw_recall_req = 1'b0; sram_wr = 1'b0;
        store_done = 1'b1; tick(); store_done = 1'b0;
        tick();
        chk("R10 no recall after store", clear_start, 1'b0);
        chk("R10 idle after store", mem_inhibit, 1'b0);

        // R11 timeout
        write_once();
        sw_store_req = 1'b1; tick(); sw_store_req = 1'b0;
        chk("R11 store started", store_start, 1'b1);
        for (int k = 1; k < TMO; k++) tick();
        chk("R11 no error before limit", timeout_err, 1'b0);
        chk("R11 still inhibited", mem_inhibit, 1'b1);
        tick();
        chk("R11 error raised", timeout_err, 1'b1);
        chk("R11 back to idle", mem_inhibit, 1'b0);
        tick(); tick();
        chk("R11 error sticky", timeout_err, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule